// File: doc/BRIEF.md
# Polled Keyboard and Display Register Interface

This block joins one character input device and one character output device to a shared processor bus on which memory and peripherals use the same address space. It decodes the low-order address bits while the bus asserts its I/O-access strobe. Inside a small aligned window it exposes four byte-wide registers: the received character, the character to show, a flag register and an enable register. Every bus access completes in the cycle it is presented. Read data is returned combinationally, and any side effect of the access lands on the following clock edge.

Polling software waits until the "character waiting" flag reads 1 and then reads the received character, which lowers that flag. To show a character, software waits until the "display can accept" flag reads 1 and then writes the character. That flag then stays low until the display side has taken the byte over a valid/ready handshake. A character that arrives while the previous one is still unread raises a sticky overrun flag. The two interrupt-request bits are computed and can be read, but they drive no pin.

Top module: `kbd_disp_port`

## Requirements
- R1: A bus access takes effect only while `bus_io_sel` is 1 and `bus_addr[DEC_W-1:OFS_W]` equals `BASE_ADDR[DEC_W-1:OFS_W]`; address bits at or above DEC_W are ignored. Any other access reads as 0 and changes nothing.
- R2: Within the window, offset 0 is the received-character register, offset 1 the output-character register, offset 2 the flag register and offset 3 the enable register. Offsets 4 to 2^OFS_W-1 read as 0 and ignore writes.
- R3: A character arriving with `kbd_valid` is stored, and flag bit 0 (character waiting) reads 1 from the next cycle. A bus read of offset 0 returns the stored character, and bit 0 reads 0 from the next cycle.
- R4: A character arriving while bit 0 is 1, and not being read in that same cycle, replaces the stored character and sets flag bit 2 (overrun). Bit 2 stays set until a bus write to offset 2 with data bit 2 equal to 1; writes with that bit 0 leave it set.
- R5: A read of offset 0 in the same cycle as a character arrival returns the old character and stores the new one. Bit 0 stays 1 and bit 2 is not set.
- R6: A bus write to offset 1 drives the byte on `disp_char` with `disp_valid` 1 from the next cycle, and flag bit 1 (display can accept) reads 0. The byte holds steady until a cycle with `disp_valid` and `disp_ready` both 1; after that, `disp_valid` is 0 and bit 1 reads 1.
- R7: A write to offset 1 while a byte is still pending replaces that byte. A write in the handshake cycle lets the old byte go and leaves the new byte pending. A read of offset 1 returns the last byte written.
- R8: The enable register at offset 3 is 8 bits, readable and writable; bit 0 enables the input request and bit 1 enables the output request. Flag bit 4 reads (bit 0 of offset 3) AND (character waiting). Flag bit 3 reads (bit 1 of offset 3) AND (display can accept). Flag bits 7:5 read 0.
- R9: Synchronous active-high `rst` clears the stored characters, the enable register, the waiting flag, the overrun flag and the pending output byte. After reset the flag register reads 0x02 and `disp_valid` is 0.
- R10: A bus write to offset 0 changes nothing, and a write to offset 2 changes nothing except the overrun clear. Offset 0 keeps returning the last received character after it has been read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_io_sel | input | 1 | I/O-access strobe from the bus master |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Bus address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when not addressed |
| kbd_valid | input | 1 | A character is presented this cycle (always taken) |
| kbd_char | input | DATA_W | Incoming character |
| disp_valid | output | 1 | An output byte is pending |
| disp_char | output | DATA_W | Pending output byte |
| disp_ready | input | 1 | Display takes the byte when this and disp_valid are both 1 |

## Verification
Two pairs of events can fall in the same cycle. The first is a bus read of the received character together with an arriving keystroke. The second is a bus write of an output byte together with the display accepting the previous byte. The bench provokes each collision by driving both inputs in one clock cycle. For the first pair it judges the read data captured in that cycle, then the flag register and a second read that follows: the old character must come back, the new one must be kept, and no overrun may appear. For the second pair it judges `disp_valid` and `disp_char` after the edge: the new byte must still be pending.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

  // Register offsets inside the decoded window; software relies on these.
  typedef enum logic [1:0] {
    OFS_RXCHAR = 2'd0,
    OFS_TXCHAR = 2'd1,
    OFS_FLAGS  = 2'd2,
    OFS_ENABLE = 2'd3
  } reg_sel_e;

  localparam int FLG_OVR_BIT = 2;
  localparam int ENA_RX_BIT  = 0;
  localparam int ENA_TX_BIT  = 1;

  // Flag register layout, MSB first so that sin lands on bit 0.
  typedef struct packed {
    logic rx_req;   // bit 4
    logic tx_req;   // bit 3
    logic ovr;      // bit 2
    logic tx_room;  // bit 1
    logic rx_full;  // bit 0
  } flags_t;

  function automatic flags_t pack_flags(input logic rx_full, input logic tx_room,
                                        input logic ovr, input logic rx_en,
                                        input logic tx_en);
    flags_t f;
    f.rx_full = rx_full;
    f.tx_room = tx_room;
    f.ovr     = ovr;
    f.tx_req  = tx_en & tx_room;
    f.rx_req  = rx_en & rx_full;
    return f;
  endfunction

  // Offsets at and above 4 exist in the window but hold nothing.
  function automatic logic offset_mapped(input logic [7:0] ofs);
    return ofs < 8'd4;
  endfunction

endpackage

// File: rtl/kdp_addr_decode.sv
module kdp_addr_decode #(
  parameter int DEC_W = 8,
  parameter int OFS_W = 3,
  parameter logic [DEC_W-1:0] BASE_LOW = 8'hF0
) (
  input  logic              io_sel,
  input  logic [DEC_W-1:0]  addr_low,
  output logic              hit,
  output logic              mapped,
  output kdp_pkg::reg_sel_e reg_sel
);
  import kdp_pkg::*;

  logic             window_match;
  logic [OFS_W-1:0] offset;

  assign offset       = addr_low[OFS_W-1:0];
  assign window_match = (addr_low[DEC_W-1:OFS_W] == BASE_LOW[DEC_W-1:OFS_W]);
  assign hit          = io_sel & window_match;
  assign mapped       = hit & offset_mapped(8'(offset));
  assign reg_sel      = reg_sel_e'(offset[1:0]);

endmodule

// File: rtl/kdp_kbd_side.sv
module kdp_kbd_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_char,
  input  logic              rd_take,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] char_q,
  output logic              rx_full,
  output logic              ovr
);

  logic overrun_evt;
  logic full_next;

  assign overrun_evt = kbd_valid & rx_full & ~rd_take;
  assign full_next   = kbd_valid | (rx_full & ~rd_take);

  always_ff @(posedge clk) begin
    if (rst) begin
      char_q  <= '0;
      rx_full <= 1'b0;
      ovr     <= 1'b0;
    end else begin
      if (kbd_valid) char_q <= kbd_char;
      rx_full <= full_next;
      if (overrun_evt)  ovr <= 1'b1;
      else if (ovr_clr) ovr <= 1'b0;
    end
  end

  p_char_sets_full_r3: assert property (@(posedge clk) disable iff (rst)
    kbd_valid |=> rx_full);

  p_read_clears_full_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_take && !kbd_valid) |=> !rx_full);

  p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    (ovr && !ovr_clr) |=> ovr);

  p_collide_no_ovr_r5: assert property (@(posedge clk) disable iff (rst)
    (kbd_valid && rd_take && !ovr) |=> (!ovr && rx_full));

endmodule

// File: rtl/kdp_disp_side.sv
module kdp_disp_side #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              disp_ready,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char
);

  logic accept_evt;

  assign accept_evt = disp_valid & disp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_char  <= '0;
    end else begin
      if (wr_load) disp_char <= wr_byte;
      disp_valid <= wr_load | (disp_valid & ~accept_evt);
    end
  end

  p_write_pends_r6: assert property (@(posedge clk) disable iff (rst)
    wr_load |=> (disp_valid && disp_char == $past(wr_byte)));

  p_accept_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (accept_evt && !wr_load) |=> !disp_valid);

  p_byte_steady_r7: assert property (@(posedge clk) disable iff (rst)
    (disp_valid && !wr_load) |=> $stable(disp_char));

endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port #(
  parameter int ADDR_W = 16,
  parameter int DEC_W  = 8,
  parameter int OFS_W  = 3,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_io_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  input  logic [DATA_W-1:0] kbd_char,
  output logic              disp_valid,
  output logic [DATA_W-1:0] disp_char,
  input  logic              disp_ready
);
  import kdp_pkg::*;

  localparam logic [DEC_W-1:0] BASE_LOW = BASE_ADDR[DEC_W-1:0];

  logic              hit, mapped;
  reg_sel_e          reg_sel;
  logic              rd_rx, wr_tx, wr_flags, wr_enable, ovr_clr;
  logic [DATA_W-1:0] rx_char;
  logic              rx_full, ovr;
  logic [DATA_W-1:0] enable_q;
  flags_t            flags;

  generate
    if (DEC_W < ADDR_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^bus_addr[ADDR_W-1:DEC_W];
    end
  endgenerate

  kdp_addr_decode #(.DEC_W(DEC_W), .OFS_W(OFS_W), .BASE_LOW(BASE_LOW)) u_dec (
    .io_sel   (bus_io_sel),
    .addr_low (bus_addr[DEC_W-1:0]),
    .hit      (hit),
    .mapped   (mapped),
    .reg_sel  (reg_sel)
  );

  // Named access strobes
  assign rd_rx     = mapped & ~bus_wr & (reg_sel == OFS_RXCHAR);
  assign wr_tx     = mapped &  bus_wr & (reg_sel == OFS_TXCHAR);
  assign wr_flags  = mapped &  bus_wr & (reg_sel == OFS_FLAGS);
  assign wr_enable = mapped &  bus_wr & (reg_sel == OFS_ENABLE);
  assign ovr_clr   = wr_flags & bus_wdata[FLG_OVR_BIT];

  kdp_kbd_side #(.DATA_W(DATA_W)) u_kbd (
    .clk       (clk),
    .rst       (rst),
    .kbd_valid (kbd_valid),
    .kbd_char  (kbd_char),
    .rd_take   (rd_rx),
    .ovr_clr   (ovr_clr),
    .char_q    (rx_char),
    .rx_full   (rx_full),
    .ovr       (ovr)
  );

  kdp_disp_side #(.DATA_W(DATA_W)) u_disp (
    .clk        (clk),
    .rst        (rst),
    .wr_load    (wr_tx),
    .wr_byte    (bus_wdata),
    .disp_ready (disp_ready),
    .disp_valid (disp_valid),
    .disp_char  (disp_char)
  );

  always_ff @(posedge clk) begin
    if (rst)            enable_q <= '0;
    else if (wr_enable) enable_q <= bus_wdata;
  end

  assign flags = pack_flags(rx_full, ~disp_valid, ovr,
                            enable_q[ENA_RX_BIT], enable_q[ENA_TX_BIT]);

  always_comb begin
    bus_rdata = '0;
    if (mapped && !bus_wr) begin
      unique case (reg_sel)
        OFS_RXCHAR: bus_rdata = rx_char;
        OFS_TXCHAR: bus_rdata = disp_char;
        OFS_FLAGS:  bus_rdata = DATA_W'(flags);
        OFS_ENABLE: bus_rdata = enable_q;
        default:    bus_rdata = '0;
      endcase
    end
  end

  p_idle_reads_zero_r1: assert property (@(posedge clk) disable iff (rst)
    !bus_io_sel |-> (bus_rdata == '0));

  p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (hit && !mapped) |-> (bus_rdata == '0));

  p_req_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (mapped && !bus_wr && reg_sel == OFS_FLAGS) |->
      (bus_rdata[4] == (enable_q[0] & bus_rdata[0]) &&
       bus_rdata[3] == (enable_q[1] & bus_rdata[1])));

  p_enable_holds_r8: assert property (@(posedge clk) disable iff (rst)
    !wr_enable |=> $stable(enable_q));

endmodule

// File: tb/kbd_disp_port_tb.sv
`timescale 1ns/1ps
module kbd_disp_port_tb;

  localparam logic [15:0] BASE = 16'h00F0;

  logic       clk = 1'b0;
  logic       rst;
  logic       bus_io_sel, bus_wr;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       kbd_valid;
  logic [7:0] kbd_char;
  logic       disp_valid;
  logic [7:0] disp_char;
  logic       disp_ready;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  kbd_disp_port u_dut (
    .clk(clk), .rst(rst), .bus_io_sel(bus_io_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_char(kbd_char), .disp_valid(disp_valid),
    .disp_char(disp_char), .disp_ready(disp_ready)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // One cycle, called at a falling edge; returns at the next falling edge.
  task automatic cyc(input logic sel, input logic wr, input logic [15:0] a,
                     input logic [7:0] wd, input logic kv, input logic [7:0] kc,
                     input logic dr, output logic [7:0] rd);
    bus_io_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    kbd_valid = kv; kbd_char = kc; disp_ready = dr;
    #2 rd = bus_rdata;
    @(negedge clk);
    bus_io_sel = 1'b0; bus_wr = 1'b0; kbd_valid = 1'b0; disp_ready = 1'b0;
  endtask

  task automatic rd_reg(input logic [15:0] a, output logic [7:0] d);
    cyc(1'b1, 1'b0, a, 8'h00, 1'b0, 8'h00, 1'b0, d);
  endtask

  task automatic wr_reg(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] x;
    cyc(1'b1, 1'b1, a, d, 1'b0, 8'h00, 1'b0, x);
  endtask

  task automatic key(input logic [7:0] c);
    logic [7:0] x;
    cyc(1'b0, 1'b0, BASE, 8'h00, 1'b1, c, 1'b0, x);
  endtask

  task automatic take_byte();
    logic [7:0] x;
    cyc(1'b0, 1'b0, BASE, 8'h00, 1'b0, 8'h00, 1'b1, x);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 disp_valid after reset", {7'd0, disp_valid}, 8'h00);
    rd_reg(BASE + 2, d); check("R9 flags after reset", d, 8'h02);
    rd_reg(BASE + 3, d); check("R9 enable after reset", d, 8'h00);
    rd_reg(BASE + 0, d); check("R9 rx char after reset", d, 8'h00);
  endtask

  task automatic t_decode();
    logic [7:0] d;
    cyc(1'b0, 1'b0, BASE + 2, 8'h00, 1'b0, 8'h00, 1'b0, d);
    check("R1 read without strobe", d, 8'h00);
    rd_reg(16'hABF2, d); check("R1 upper bits ignored", d, 8'h02);
    rd_reg(16'h00E2, d); check("R1 outside window reads 0", d, 8'h00);
    wr_reg(16'h00E3, 8'h03);
    cyc(1'b0, 1'b1, BASE + 3, 8'h55, 1'b0, 8'h00, 1'b0, d);
    rd_reg(BASE + 3, d); check("R1 stray writes ignored", d, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    for (int i = 4; i < 8; i++) begin
      wr_reg(BASE + 16'(i), 8'hFF);
      rd_reg(BASE + 16'(i), d); check("R2 unmapped offset reads 0", d, 8'h00);
    end
    rd_reg(BASE + 3, d); check("R2 enable untouched", d, 8'h00);
    rd_reg(BASE + 2, d); check("R2 flags untouched", d, 8'h02);
  endtask

  task automatic t_keyboard();
    logic [7:0] d;
    key(8'h41);
    rd_reg(BASE + 2, d); check("R3 waiting flag set", d, 8'h03);
    rd_reg(BASE + 0, d); check("R3 char returned", d, 8'h41);
    rd_reg(BASE + 2, d); check("R3 waiting flag cleared", d, 8'h02);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    key(8'h11); key(8'h22);
    rd_reg(BASE + 2, d); check("R4 overrun set", d, 8'h07);
    rd_reg(BASE + 0, d); check("R4 newest char kept", d, 8'h22);
    rd_reg(BASE + 2, d); check("R4 overrun sticky after read", d, 8'h06);
    wr_reg(BASE + 2, 8'h00);
    rd_reg(BASE + 2, d); check("R4 zero write keeps overrun", d, 8'h06);
    wr_reg(BASE + 2, 8'h04);
    rd_reg(BASE + 2, d); check("R4 overrun cleared", d, 8'h02);
  endtask

  task automatic t_collide_kbd();
    logic [7:0] d;
    key(8'h33);
    cyc(1'b1, 1'b0, BASE + 0, 8'h00, 1'b1, 8'h44, 1'b0, d);
    check("R5 collision returns old char", d, 8'h33);
    rd_reg(BASE + 2, d); check("R5 still waiting, no overrun", d, 8'h03);
    rd_reg(BASE + 0, d); check("R5 new char kept", d, 8'h44);
    rd_reg(BASE + 2, d); check("R5 flags after drain", d, 8'h02);
  endtask

  task automatic t_display();
    logic [7:0] d;
    wr_reg(BASE + 1, 8'h5A);
    check("R6 disp_valid after write", {7'd0, disp_valid}, 8'h01);
    check("R6 disp_char after write", disp_char, 8'h5A);
    rd_reg(BASE + 2, d); check("R6 room flag cleared", d, 8'h00);
    repeat (2) @(negedge clk);
    check("R6 byte held while not ready", disp_char, 8'h5A);
    check("R6 valid held while not ready", {7'd0, disp_valid}, 8'h01);
    take_byte();
    check("R6 valid drops after handshake", {7'd0, disp_valid}, 8'h00);
    rd_reg(BASE + 2, d); check("R6 room flag restored", d, 8'h02);
  endtask

  task automatic t_collide_disp();
    logic [7:0] d;
    wr_reg(BASE + 1, 8'h61);
    wr_reg(BASE + 1, 8'h62);
    check("R7 pending byte replaced", disp_char, 8'h62);
    cyc(1'b1, 1'b1, BASE + 1, 8'h63, 1'b0, 8'h00, 1'b1, d);
    check("R7 new byte pending after handshake write", {7'd0, disp_valid}, 8'h01);
    check("R7 new byte on port", disp_char, 8'h63);
    rd_reg(BASE + 1, d); check("R7 out register readback", d, 8'h63);
    take_byte();
    check("R7 drained", {7'd0, disp_valid}, 8'h00);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    wr_reg(BASE + 3, 8'hA5);
    rd_reg(BASE + 3, d); check("R8 enable readback", d, 8'hA5);
    rd_reg(BASE + 2, d); check("R8 no request without data", d, 8'h02);
    key(8'h10);
    rd_reg(BASE + 2, d); check("R8 input request", d, 8'h13);
    wr_reg(BASE + 3, 8'h02);
    rd_reg(BASE + 2, d); check("R8 output request", d, 8'h0B);
    rd_reg(BASE + 0, d); check("R8 char read", d, 8'h10);
    rd_reg(BASE + 2, d); check("R8 output request only", d, 8'h0A);
    wr_reg(BASE + 3, 8'h00);
  endtask

  task automatic t_ignored();
    logic [7:0] d;
    wr_reg(BASE + 0, 8'h77);
    rd_reg(BASE + 0, d); check("R10 rx char write ignored", d, 8'h10);
    rd_reg(BASE + 2, d); check("R10 waiting flag not set by write", d, 8'h02);
    wr_reg(BASE + 2, 8'hFB);
    rd_reg(BASE + 2, d); check("R10 flag write ignored", d, 8'h02);
    check("R10 display untouched", {7'd0, disp_valid}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_io_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    kbd_valid = 1'b0; kbd_char = '0; disp_ready = 1'b0;
    @(negedge clk);
    t_reset();
    t_decode();
    t_unmapped();
    t_keyboard();
    t_overrun();
    t_collide_kbd();
    t_display();
    t_collide_disp();
    t_enable();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule